// File: doc/BRIEF.md
# Listener-to-Printer Parallel Bridge

This block sits on a shared parallel instrument bus as a listen-only device and copies every data byte it accepts onto a printer-style parallel port. On the bus side it decodes addressing commands, sent while the attention line is low, to learn whether it is the current listener. While it is listening it runs the three-wire acceptor handshake for each data byte. On the printer side it presents the byte on eight data lines and passes it over with an active-low strobe. The printer answers with an active-low acknowledge, and a busy input lets the printer hold off a transfer.

The bridge holds one byte. A byte counts as consumed only when the whole printer handshake has finished, including the return of acknowledge to high. Until then the bus is told the bridge is not ready. When the bridge is not addressed it releases both of its bus handshake lines, so it never stalls traffic meant for other devices. An offline switch input freezes both sides at their idle points. All bus inputs are taken to be synchronous to `clk`. The bus data lines carry the true byte value, and the handshake lines are active-low.

Top module: `par_print_bridge`

## Requirements
- R1: After reset `bus_notready_n`, `bus_notaccepted_n` and `prn_stb_n` are all 1, `prn_data` is 0, and the bridge is unaddressed.
- R2: A byte accepted while `bus_cmd_n` is 0 is a command, and bit 7 is ignored. With bits 6:5 = 01 and bits 4:0 = LISTEN_ADDR it makes the bridge a listener. Bits 6:0 = 7'h3F make it stop listening. Talk commands (bits 6:5 = 10) and listen commands for other addresses leave the addressed state unchanged.
- R3: While the bridge is unaddressed and `bus_cmd_n` is 1, both `bus_notready_n` and `bus_notaccepted_n` are 1, and no byte is taken.
- R4: Acceptor handshake. When ready, the bridge shows `bus_notready_n`=1 and `bus_notaccepted_n`=0. The clock edge that sees `bus_valid_n`=0 captures the byte, after which `bus_notready_n`=0 and `bus_notaccepted_n`=1. These hold until `bus_valid_n` returns to 1.
- R5: Command bytes never reach the printer port.
- R6: Every data byte taken while listening is sent to the printer unchanged and in arrival order.
- R7: `bus_notready_n` is driven 0 in the ready phase only while the bridge is addressed and either holds an unfinished byte or is offline. A new data byte is refused until the printer acknowledge of the previous byte has returned to 1.
- R8: A printer transfer starts only in a cycle where `prn_busy` is 0.
- R9: `prn_data` shows the byte for exactly SETTLE_CYC cycles before `prn_stb_n` falls, and stays stable while `prn_stb_n` is 0.
- R10: One cycle after the bridge sees `prn_ack_n`=0 with strobe low, `prn_stb_n` is 1 and `prn_data` is 0. The transfer ends when `prn_ack_n` returns to 1.
- R11: While `offline` is 1, no new printer transfer starts and no data byte is taken. Commands are still handled.
- R12: `bus_clear_n`=0 unaddresses the bridge, drops any pending byte and returns every output to its R1 value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 8 | Bus data byte (true value) |
| bus_valid_n | input | 1 | Talker data-valid, active low |
| bus_cmd_n | input | 1 | Attention: byte is a command, active low |
| bus_clear_n | input | 1 | Bus interface clear, active low |
| bus_notready_n | output | 1 | Acceptor not-ready, active low |
| bus_notaccepted_n | output | 1 | Acceptor not-accepted, active low |
| prn_data | output | 8 | Printer data lines |
| prn_stb_n | output | 1 | Printer strobe, active low |
| prn_ack_n | input | 1 | Printer acknowledge, active low |
| prn_busy | input | 1 | Printer busy, active high |
| offline | input | 1 | Offline switch, holds both sides idle |

## Verification
A wrong addressed state shows up at once in the bus handshake lines. A stray listener drives the not-accepted line low on the first idle cycle after attention is released. A lost listener leaves both lines high when a byte is due. A wrong buffer or printer state shows up as a not-ready line that opens while the acknowledge is still low, or as a strobe that falls too early, late or while busy. Every byte printed is compared against the order of the bytes the bench sent, so a dropped, duplicated or command byte is visible at the end of each stream.

// File: rtl/par_print_bridge.sv
module par_print_bridge #(
  parameter logic [4:0] LISTEN_ADDR = 5'd9,
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_data,
  input  logic       bus_valid_n,
  input  logic       bus_cmd_n,
  input  logic       bus_clear_n,
  output logic       bus_notready_n,
  output logic       bus_notaccepted_n,
  output logic [7:0] prn_data,
  output logic       prn_stb_n,
  input  logic       prn_ack_n,
  input  logic       prn_busy,
  input  logic       offline
);

  localparam int CW = $clog2(SETTLE_CYC + 1);

  typedef enum logic [1:0] {A_OFF, A_READY, A_TAKE} acc_t;
  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_STROBE, P_RELEASE} prn_t;

  acc_t a_state;
  prn_t p_state;
  logic listening, buf_full;
  logic [7:0] buf_q;
  logic [CW-1:0] settle_q;

  wire attn      = !bus_cmd_n;
  wire engaged   = attn || listening;
  wire can_take  = attn || (!buf_full && !offline);
  wire take      = (a_state == A_READY) && engaged && can_take && !bus_valid_n;
  wire is_unl    = bus_data[6:0] == 7'h3F;
  wire is_my_lsn = (bus_data[6:5] == 2'b01) && (bus_data[4:0] == LISTEN_ADDR);
  wire done      = (p_state == P_RELEASE) && prn_ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_state   <= A_OFF;
      listening <= 1'b0;
      buf_full  <= 1'b0;
      buf_q     <= '0;
    end else if (!bus_clear_n) begin
      a_state   <= A_OFF;
      listening <= 1'b0;
      buf_full  <= 1'b0;
      buf_q     <= '0;
    end else begin
      case (a_state)
        A_OFF:   if (engaged) a_state <= A_READY;
        A_READY: if (!engaged) a_state <= A_OFF;
                 else if (take) a_state <= A_TAKE;
        A_TAKE:  if (bus_valid_n) a_state <= engaged ? A_READY : A_OFF;
        default: a_state <= A_OFF;
      endcase
      if (take && attn) begin
        if (is_unl) listening <= 1'b0;
        else if (is_my_lsn) listening <= 1'b1;
      end
      if (take && !attn) begin
        buf_q    <= bus_data;
        buf_full <= 1'b1;
      end else if (done) begin
        buf_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_state  <= P_IDLE;
      settle_q <= '0;
    end else if (!bus_clear_n) begin
      p_state  <= P_IDLE;
      settle_q <= '0;
    end else begin
      case (p_state)
        P_IDLE:
          if (buf_full && !offline && !prn_busy) begin
            p_state  <= P_SETUP;
            settle_q <= CW'(SETTLE_CYC - 1);
          end
        P_SETUP:
          if (settle_q == '0) p_state <= P_STROBE;
          else settle_q <= settle_q - 1'b1;
        P_STROBE:  if (!prn_ack_n) p_state <= P_RELEASE;
        P_RELEASE: if (prn_ack_n) p_state <= P_IDLE;
        default:   p_state <= P_IDLE;
      endcase
    end
  end

  assign bus_notaccepted_n = a_state != A_READY;
  assign bus_notready_n    = (a_state == A_OFF) ||
                             ((a_state == A_READY) && (can_take || !engaged));
  assign prn_stb_n = p_state != P_STROBE;
  assign prn_data  = ((p_state == P_SETUP) || (p_state == P_STROBE)) ? buf_q : 8'h00;

endmodule

// File: rtl/par_print_bridge_chk.sv
module par_print_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_clear_n,
  input logic       bus_cmd_n,
  input logic       bus_notready_n,
  input logic       bus_notaccepted_n,
  input logic [7:0] prn_data,
  input logic       prn_stb_n,
  input logic       prn_ack_n,
  input logic       listening,
  input logic       buf_full
);

  a_r12_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clear_n |=> (prn_stb_n && bus_notready_n && bus_notaccepted_n && prn_data == 8'h00));

  a_r7_notready_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_notready_n && !bus_notaccepted_n) |-> listening);

  a_r7_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_notready_n && !bus_notaccepted_n && bus_cmd_n && listening) |-> (prn_stb_n && !buf_full));

  a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!prn_stb_n && $past(!prn_stb_n)) |-> $stable(prn_data));

  a_r9_data_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prn_stb_n) |-> $stable(prn_data));

  a_r10_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!prn_stb_n && !prn_ack_n) |=> prn_stb_n);

endmodule

bind par_print_bridge par_print_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_clear_n(bus_clear_n), .bus_cmd_n(bus_cmd_n),
  .bus_notready_n(bus_notready_n), .bus_notaccepted_n(bus_notaccepted_n),
  .prn_data(prn_data), .prn_stb_n(prn_stb_n), .prn_ack_n(prn_ack_n),
  .listening(listening), .buf_full(buf_full)
);

// File: tb/par_print_bridge_bench.sv
`timescale 1ns/1ps
module par_print_bridge_bench;
  localparam logic [4:0] ADDR = 5'd9;
  localparam int SETTLE = 4;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_data = 0;
  logic bus_valid_n = 1, bus_cmd_n = 1, bus_clear_n = 1;
  logic bus_notready_n, bus_notaccepted_n, prn_stb_n;
  logic [7:0] prn_data;
  logic prn_ack_n = 1, prn_busy = 0, offline = 0;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_a [0:255];
  logic [7:0] got_a [0:255];
  int exp_n = 0, got_n = 0;
  bit auto_prn = 0, rand_busy = 0;
  int run_len = 0, last_setup = -1;
  logic prev_stb = 1;

  always #2.5 clk = ~clk;

  par_print_bridge #(.LISTEN_ADDR(ADDR), .SETTLE_CYC(SETTLE)) u_par_print_bridge (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_valid_n(bus_valid_n),
    .bus_cmd_n(bus_cmd_n), .bus_clear_n(bus_clear_n), .bus_notready_n(bus_notready_n),
    .bus_notaccepted_n(bus_notaccepted_n), .prn_data(prn_data), .prn_stb_n(prn_stb_n),
    .prn_ack_n(prn_ack_n), .prn_busy(prn_busy), .offline(offline));

  function automatic logic [7:0] listen_cmd(input logic [4:0] a);
    return {3'b001, a};
  endfunction
  function automatic logic [7:0] talk_cmd(input logic [4:0] a);
    return {3'b010, a};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic talk(input bit atn, input logic [7:0] b);
    int t;
    @(negedge clk);
    bus_cmd_n = !atn;
    bus_data = b;
    t = 0;
    while (!(bus_notready_n && !bus_notaccepted_n) && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R4 ready before byte", t, 0);
    if (t < 3000) begin
      bus_valid_n = 0;
      @(negedge clk);
      chk(bus_notaccepted_n && !bus_notready_n, "R4 accepted after valid",
          {bus_notaccepted_n, bus_notready_n}, 2'b10);
      bus_valid_n = 1;
      @(negedge clk);
    end
    bus_cmd_n = 1;
  endtask

  task automatic probe(input logic [7:0] b, input logic exp_nr, input logic exp_na, input string req);
    @(negedge clk);
    bus_cmd_n = 1;
    bus_data = b;
    tick(3);
    chk(bus_notready_n == exp_nr && bus_notaccepted_n == exp_na, req,
        {bus_notready_n, bus_notaccepted_n}, {exp_nr, exp_na});
  endtask

  task automatic wait_stb_low(input int lim, output bit ok);
    int t = 0;
    while (prn_stb_n && t < lim) begin @(negedge clk); t++; end
    ok = !prn_stb_n;
  endtask

  task automatic manual_ack();
    prn_ack_n = 0;
    @(negedge clk);
    while (!prn_stb_n) @(negedge clk);
    prn_ack_n = 1;
    tick(2);
  endtask

  always @(negedge clk) begin
    if (prn_stb_n && prn_data != 8'h00) run_len <= run_len + 1;
    else if (prn_stb_n) run_len <= 0;
    if (prev_stb && !prn_stb_n) last_setup <= run_len;
    prev_stb <= prn_stb_n;
  end

  initial forever begin
    @(negedge clk);
    if (auto_prn && !prn_stb_n) begin
      got_a[got_n[7:0]] = prn_data;
      got_n++;
      repeat ($urandom_range(0, 4)) @(negedge clk);
      prn_ack_n = 0;
      while (!prn_stb_n) @(negedge clk);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      prn_ack_n = 1;
    end
  end

  initial forever begin
    @(negedge clk);
    if (rand_busy && $urandom_range(0, 3) == 0) prn_busy = !prn_busy;
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit ok;
    int g0;
    void'($urandom(32'h5eed));
    tick(3);
    chk(bus_notready_n && bus_notaccepted_n && prn_stb_n && prn_data == 0,
        "R1 reset outputs", {bus_notready_n, bus_notaccepted_n, prn_stb_n}, 3'b111);
    rst_n = 1;
    tick(2);

    probe(8'h55, 1, 1, "R3 unaddressed releases both lines");
    talk(1, talk_cmd(ADDR));
    probe(8'h55, 1, 1, "R2 talk command does not address");
    talk(1, listen_cmd(5'd3));
    probe(8'h55, 1, 1, "R2 other listen address ignored");
    talk(1, listen_cmd(ADDR) | 8'h80);
    probe(8'h55, 1, 0, "R2 own listen address (bit7 ignored)");
    chk(prn_stb_n, "R5 command not forwarded", prn_stb_n, 1);

    talk(0, 8'hA5);
    wait_stb_low(50, ok);
    chk(ok && prn_data == 8'hA5, "R6 byte unchanged", prn_data, 8'hA5);
    @(negedge clk);
    chk(last_setup == SETTLE, "R9 settle cycles", last_setup, SETTLE);
    probe(8'h66, 0, 0, "R7 refused while byte pending");
    prn_ack_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk(prn_stb_n && prn_data == 0, "R10 strobe high and data cleared after ack",
        {prn_stb_n, prn_data}, 9'h100);
    tick(3);
    chk(!bus_notready_n, "R7 still refused while ack low", bus_notready_n, 0);
    prn_ack_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(bus_notready_n && !bus_notaccepted_n, "R7 ready after ack high",
        {bus_notready_n, bus_notaccepted_n}, 2'b10);

    prn_busy = 1;
    talk(0, 8'h3C);
    tick(20);
    chk(prn_stb_n, "R8 no strobe while busy", prn_stb_n, 1);
    prn_busy = 0;
    wait_stb_low(SETTLE + 4, ok);
    chk(ok && prn_data == 8'h3C, "R8 starts after busy low", prn_data, 8'h3C);
    manual_ack();

    prn_busy = 1;
    talk(0, 8'h77);
    offline = 1;
    @(negedge clk);
    prn_busy = 0;
    tick(20);
    chk(prn_stb_n, "R11 printer stays idle offline", prn_stb_n, 1);
    offline = 0;
    wait_stb_low(SETTLE + 4, ok);
    chk(ok && prn_data == 8'h77, "R11 resumes when online", prn_data, 8'h77);
    manual_ack();

    offline = 1;
    probe(8'h12, 0, 0, "R11 bus refuses data offline");
    talk(1, talk_cmd(5'd2));
    chk(prn_stb_n, "R11 command still handled offline", prn_stb_n, 1);
    offline = 0;
    probe(8'h12, 1, 0, "R7 ready again online");

    auto_prn = 1;
    rand_busy = 1;
    got_n = 0;
    exp_n = 0;
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        talk(1, ($urandom_range(0, 1) == 1) ? talk_cmd(ADDR) : listen_cmd(ADDR));
      end else begin
        logic [7:0] b;
        b = 8'($urandom_range(0, 255));
        exp_a[exp_n[7:0]] = b;
        exp_n++;
        talk(0, b);
      end
    end
    for (int t = 0; t < 2000 && got_n < exp_n; t++) @(negedge clk);
    chk(got_n == exp_n, "R5 count matches data bytes only", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_a[i] == exp_a[i], "R6 order and value", got_a[i], exp_a[i]);
    rand_busy = 0;
    prn_busy = 0;
    tick(5);

    talk(1, 8'h3F);
    g0 = got_n;
    probe(8'h44, 1, 1, "R2 unlisten stops forwarding");
    tick(20);
    chk(got_n == g0, "R3 nothing forwarded when unaddressed", got_n, g0);

    talk(1, listen_cmd(ADDR));
    prn_busy = 1;
    talk(0, 8'h11);
    @(negedge clk);
    bus_clear_n = 0;
    @(negedge clk);
    chk(prn_stb_n && bus_notready_n && bus_notaccepted_n, "R12 clear idles outputs",
        {prn_stb_n, bus_notready_n, bus_notaccepted_n}, 3'b111);
    bus_clear_n = 1;
    prn_busy = 0;
    g0 = got_n;
    tick(30);
    chk(got_n == g0, "R12 pending byte dropped", got_n, g0);
    probe(8'h22, 1, 1, "R12 unaddressed after clear");

    finish_run();
  end
endmodule